// File: doc/BRIEF.md
# Bit-exact single-to-double widener

This block widens a 32-bit IEEE-754 single-precision word into a 64-bit double-precision word on the load path of a core. That core keeps every floating-point register in double format, so every single-precision load passes through this block. The conversion is a pure reformat and never an arithmetic operation. It does not depend on any flush-to-zero or denormals-are-zero setting elsewhere in the core. Subnormal singles are renormalised into ordinary doubles and are never flushed. A signalling NaN keeps its quiet bit clear, and all NaN payload bits are carried across.

The widened value is copied into both 64-bit lanes of a 128-bit paired register. A word is accepted with a valid/ready handshake. The result appears in a single output register one cycle later and is held there for as long as the consumer withholds `out_ready`.

Top module: `fp32_widen_pair`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: For a normal single (exponent bits [30:23] neither 0 nor 0xFF), the double keeps the sign bit (63). Its exponent [62:52] equals the single exponent plus 896. Its fraction [51:0] is the 23-bit single fraction followed by 29 zero bits.
- R3: A single zero of either sign (0x00000000 or 0x80000000) becomes a double zero with the same sign bit and all other bits 0.
- R4: A subnormal single (exponent 0, fraction nonzero) is never flushed. Let k be the position of the highest set fraction bit. The double exponent is 874+k. The double fraction is the fraction bits below k, left-aligned into bits [51:29], with zeros below.
- R5: A single infinity (exponent 0xFF, fraction 0) becomes a double with exponent 0x7FF, a zero fraction and the same sign.
- R6: A NaN is any single whose exponent field (mask 0x7F800000) is all ones and whose fraction is nonzero. Its double has exponent 0x7FF, the same sign, and the 23 fraction bits shifted left by 29. In particular, double bit 51 equals single bit 22, so a signalling NaN stays signalling.
- R7: `out_pair[127:64]` and `out_pair[63:0]` both carry the same widened double.
- R8: A word accepted (`in_valid` and `in_ready` high at a clock edge) appears on `out_pair` with `out_valid` high after exactly that one edge.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_pair` and `out_valid` do not change. When `out_ready` is high, or the output is empty, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word is present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_word | input | 32 | Single-precision bit pattern |
| out_valid | output | 1 | Output pair holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_pair | output | 128 | Widened double in both 64-bit lanes |

## Verification
The hardest behaviour to reach from uniformly random 32-bit words is the rare input classes. Subnormals with their highest set bit at every position, signalling NaNs and infinities together make up a tiny share of that space. The stimulus therefore first walks a directed list that includes the smallest and largest subnormal, a single set bit at each of several positions, and quiet and signalling NaNs. It then draws words by class, with subnormals and NaNs weighted heavily. A second hard case is a new word arriving while the output is stalled. The bench holds `in_valid` high under a low `out_ready` for several cycles and also toggles `out_ready` at random, so that the held result and the refusal of the waiting word are both observed.

// File: rtl/widen_pkg.sv
package widen_pkg;
    localparam int SGL_W     = 32;
    localparam int SE_W      = 8;
    localparam int SF_W      = SGL_W - 1 - SE_W;
    localparam int DBL_W     = 64;
    localparam int DE_W      = 11;
    localparam int DF_W      = DBL_W - 1 - DE_W;
    localparam int PAD_W     = DF_W - SF_W;
    localparam int S_BIAS    = (1 << (SE_W - 1)) - 1;
    localparam int D_BIAS    = (1 << (DE_W - 1)) - 1;
    localparam int EXP_SHIFT = D_BIAS - S_BIAS;
    localparam int LZ_W      = $clog2(SF_W + 1);
    localparam int LANES     = 2;
    localparam int PAIR_W    = LANES * DBL_W;

    typedef struct packed {
        logic             vld;
        logic [DBL_W-1:0] res;
    } wstage_t;
endpackage

// File: rtl/f2d_lzc.sv
module f2d_lzc #(
    parameter int W   = 23,
    parameter int C_W = $clog2(W + 1)
) (
    input  logic [W-1:0]   vec,
    output logic [C_W-1:0] cnt
);
    always_comb begin
        cnt = C_W'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = C_W'(W - 1 - i);
        end
    end
endmodule

// File: rtl/f2d_core.sv
module f2d_core
    import widen_pkg::*;
(
    input  logic [SGL_W-1:0] sgl,
    output logic [DBL_W-1:0] dbl
);
    logic            sgn;
    logic [SE_W-1:0] se;
    logic [SF_W-1:0] sf;
    logic [LZ_W-1:0] lz;
    logic [SF_W-1:0] sf_norm;
    logic [DE_W-1:0] de;
    logic [SF_W-1:0] fr;

    assign {sgn, se, sf} = sgl;

    f2d_lzc #(.W(SF_W), .C_W(LZ_W)) u_lzc (
        .vec (sf),
        .cnt (lz)
    );

    always_comb begin
        // drop the leading one: shift by its distance from the top plus one
        sf_norm = sf << (lz + LZ_W'(1));
        if (se == '1) begin
            de = '1;
            fr = sf;            // payload and quiet bit carried untouched
        end else if (se == '0) begin
            if (sf == '0) begin
                de = '0;
                fr = '0;
            end else begin
                de = DE_W'(EXP_SHIFT) - DE_W'(lz);
                fr = sf_norm;
            end
        end else begin
            de = DE_W'(se) + DE_W'(EXP_SHIFT);
            fr = sf;
        end
        dbl = {sgn, de, fr, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/fp32_widen_pair.sv
module fp32_widen_pair
    import widen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SGL_W-1:0]  in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PAIR_W-1:0] out_pair
);
    wstage_t          st_d, st_q;
    logic [DBL_W-1:0] conv_res;
    logic             take;

    f2d_core u_core (
        .sgl (in_word),
        .dbl (conv_res)
    );

    assign in_ready  = !st_q.vld || out_ready;
    assign take      = in_valid && in_ready;
    assign out_valid = st_q.vld;

    generate
        for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
            assign out_pair[ln*DBL_W +: DBL_W] = st_q.res;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (take) begin
            st_d.vld = 1'b1;
            st_d.res = conv_res;
        end else if (out_ready) begin
            st_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_ACCEPT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R8
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pair))); // R9
    AST_NAN_QUIET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_word[30:23] == 8'hFF && in_word[22:0] != 23'd0)
        |=> (out_pair[62:52] == 11'h7FF && out_pair[51] == $past(in_word[22]))); // R6
    AST_SUBNORMAL_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_word[30:23] == 8'h00 && in_word[22:0] != 23'd0)
        |=> (out_pair[62:52] != 11'd0)); // R4
    AST_INF_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_word[30:0] == 31'h7F800000)
        |=> (out_pair[62:0] == {11'h7FF, 52'd0})); // R5
endmodule

// File: tb/tb_fp32_widen_pair.sv
module tb_fp32_widen_pair;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_word = 32'd0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [127:0] out_pair;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    bit          mv = 1'b0;
    logic [63:0] mp = 64'd0;
    string       mtag = "R2";

    always #4 clk = ~clk;

    fp32_widen_pair dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
        .out_pair(out_pair)
    );

    function automatic logic [63:0] ref_widen(input logic [31:0] w);
        logic [7:0]  e = w[30:23];
        logic [22:0] f = w[22:0];
        logic [22:0] fr;
        int k;
        if (e == 8'hFF) return {w[31], 11'h7FF, f, 29'd0};
        if (e == 8'd0 && f == 23'd0) return {w[31], 63'd0};
        if (e == 8'd0) begin
            k = 22;
            while (!f[k]) k--;
            fr = 23'(f << (23 - k));
            return {w[31], 11'(874 + k), fr, 29'd0};
        end
        return {w[31], 11'(int'(e) + 896), f, 29'd0};
    endfunction

    function automatic string cls_tag(input logic [31:0] w);
        if (w[30:23] == 8'hFF) return (w[22:0] == 0) ? "R5" : "R6";
        if (w[30:23] == 8'd0)  return (w[22:0] == 0) ? "R3" : "R4";
        return "R2";
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // called at a negedge: drive inputs, predict the next edge, check after it
    task automatic step(input bit v, input logic [31:0] w, input bit r);
        bit acc;
        in_valid = v; in_word = w; out_ready = r;
        #1;
        chk(in_ready == (!mv || r), "R9 in_ready", 128'(in_ready), 128'(!mv || r));
        acc = v && (!mv || r);
        if (acc) begin
            mv = 1'b1; mp = ref_widen(w); mtag = cls_tag(w);
        end else if (r) begin
            mv = 1'b0;
        end
        @(negedge clk);
        chk(out_valid == mv, acc ? "R8 out_valid" : "R9 out_valid",
            128'(out_valid), 128'(mv));
        if (mv && out_valid) begin
            chk(out_pair[63:0] == mp, mtag, 128'(out_pair[63:0]), 128'(mp));
            chk(out_pair[127:64] == out_pair[63:0], "R7 lanes",
                128'(out_pair[127:64]), 128'(out_pair[63:0]));
        end
    endtask

    function automatic logic [31:0] rand_word();
        logic [31:0] x = $urandom;
        case ($urandom % 6)
            0: x[30:23] = 8'd0;
            1: begin x[30:23] = 8'd0; x[22:0] = 23'(1) << ($urandom % 23); end
            2: x[30:23] = 8'hFF;
            3: begin x[30:23] = 8'hFF; x[22] = 1'b0; end
            default: ;
        endcase
        return x;
    endfunction

    logic [31:0] corners [16] = '{32'h00000000, 32'h80000000, 32'h00000001,
        32'h007FFFFF, 32'h00400000, 32'h80000001, 32'h00000100, 32'h3F800000,
        32'h7F7FFFFF, 32'h00800000, 32'h7F800000, 32'hFF800000, 32'h7FC00000,
        32'h7F800001, 32'h7FA00000, 32'hFFBFFFFF};

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1 out_valid", 128'(out_valid), 128'(0));
        chk(in_ready == 1'b1, "R1 in_ready", 128'(in_ready), 128'(1));
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 after release", 128'(out_valid), 128'(0));

        // directed corners: R2 R3 R4 R5 R6
        foreach (corners[i]) step(1'b1, corners[i], 1'b1);
        // spot values from the requirements
        step(1'b1, 32'h7F800001, 1'b1);
        chk(out_pair[63:0] == 64'h7FF0000020000000, "R6 snan stays",
            128'(out_pair[63:0]), 128'h7FF0000020000000);
        step(1'b1, 32'h00000001, 1'b1);
        chk(out_pair[63:0] == 64'h36A0000000000000, "R4 min subnormal",
            128'(out_pair[63:0]), 128'h36A0000000000000);
        step(1'b1, 32'h3F800000, 1'b1);
        chk(out_pair[63:0] == 64'h3FF0000000000000, "R2 one",
            128'(out_pair[63:0]), 128'h3FF0000000000000);

        // R9: stall with a waiting word that must not be taken
        step(1'b1, 32'h00400000, 1'b0);
        for (int i = 0; i < 4; i++) step(1'b1, 32'h7FC00001, 1'b0);
        step(1'b0, 32'd0, 1'b1);
        step(1'b0, 32'd0, 1'b1);

        // R8: back-to-back acceptance then drain
        for (int i = 0; i < 8; i++) step(1'b1, rand_word(), 1'b1);

        // random traffic with random backpressure
        for (int i = 0; i < 4000; i++)
            step(($urandom % 4) != 0, rand_word(), ($urandom % 3) != 0);
        step(1'b0, 32'd0, 1'b1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule